// File: doc/BRIEF.md
# Display Memory Row Fetch Controller

This block pulls one character row of display data out of an external 16-bit display memory. The memory sits on a bus that is shared with a host processor, and that bus carries both address and data. When a row start pulse arrives, the block raises a bus request. It then waits out a programmable warning interval, so the host can finish whatever cycle it is running. After that it runs a fixed burst of word reads and writes each captured word into the active half of a double-buffered row store.

Each read takes three clock periods. The word address is driven onto the shared bus and marked by a falling address strobe, so external latches can hold it. The bus is then released, and both byte data strobes fall together to return a full 16-bit word. The block never writes to the display memory. A row is 40 columns of 32 bits, so a burst is 80 words. At the end of the burst the block pulses a done flag, drops the bus request and swaps buffer halves. A start pulse that arrives while a burst is running is remembered and served as soon as the burst ends.

Top module: `dispfetch_top`

## Requirements
- R1: During and after reset, busReq, busOe, bufWrEn, rowDone and bufHalf are 0, the three strobes are high (inactive), and no bus cycle starts until rowStart is seen.
- R2: readNotWrite is 1 in every cycle, so the block only ever reads.
- R3: Each word cycle lasts 3 clocks. In phase 0 the bus is driven with the address and addrStbN is high. In phase 1 the bus is still driven and addrStbN is low. In phase 2 the bus is released (busOe 0), addrStbN stays low, and upperStbN and lowerStbN are both low. Outside phase 2 both data strobes are high.
- R4: A row is 80 word reads. Word i goes to byte address ((baseAddr with bit 0 forced to 0) + 2*i) modulo 2^17. The bus carries byte-address bits 16..1, and word addresses wrap modulo 2^16.
- R5: busReq goes high in the cycle after rowStart is sampled. It stays high for W = min(16*warnSetting, 138) cycles before the first phase-0 cycle, so W = 0 starts the bus at once.
- R6: One cycle after the phase 2 of word i, bufWrEn is 1, bufWrAddr is i and bufWrData is the value busIn held during that phase 2. bufWrEn is 0 in all other cycles.
- R7: rowDone is high for exactly one cycle, one clock after the last buffer write. busReq is low in that same cycle, having been high in every cycle from the request up to the last write.
- R8: bufHalf is 0 for the first row after reset, stays constant throughout a row, and flips after each rowDone.
- R9: A rowStart that arrives while a burst is active is held. The next row then begins at the edge that ends the rowDone cycle, so busReq is low for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rowStart | input | 1 | One-cycle request to fetch a row |
| baseAddr | input | 17 | Byte address of the row's first word; bit 0 ignored |
| warnSetting | input | 8 | Warning time in steps of 16 clocks, clamped to 138 clocks |
| busReq | output | 1 | Bus request to the host, active high |
| busOut | output | 16 | Word address driven on the shared bus |
| busOe | output | 1 | Output enable for busOut |
| busIn | input | 16 | Data returned from the shared bus |
| addrStbN | output | 1 | Address strobe, active low |
| upperStbN | output | 1 | Upper byte data strobe, active low |
| lowerStbN | output | 1 | Lower byte data strobe, active low |
| readNotWrite | output | 1 | Read/write line, held at read |
| bufWrEn | output | 1 | Row buffer write enable |
| bufWrAddr | output | 7 | Word index inside the buffer half |
| bufWrData | output | 16 | Word written to the row buffer |
| bufHalf | output | 1 | Row buffer half being filled |
| rowDone | output | 1 | One-cycle pulse at the end of a row |

## Verification
Every result is tied to the edge that samples rowStart, whose following cycle is numbered 0. busReq is due in cycle 0 and the first address strobe in cycle W+1. The phase 2 of word i falls in cycle W+3i+2, its buffer write in W+3i+3, and rowDone in W+241. The bench samples on the falling clock edge and compares every output in every cycle of the row against those arithmetic predictions. It sweeps warning settings across and beyond the clamp point, uses bases that are odd or that wrap, and injects a request mid-burst. A bus model returns data that depends on the latched address, so a capture made in the wrong cycle or from the wrong address shows up as a data mismatch.

// File: rtl/dispfetch_pkg.sv
package dispfetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WARN = 3'd1,
    ST_BUS  = 3'd2,
    ST_TAIL = 3'd3,
    ST_FIN  = 3'd4
  } fetch_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBase;  // latch base address, clear write index
    logic drvAddr;   // drive word address on the bus
    logic addrStb;   // address strobe active
    logic dataStb;   // both data strobes active, sample bus at end of cycle
  } fetch_stb_t;

endpackage

// File: rtl/dispfetch_ctrl.sv
module dispfetch_ctrl
  import dispfetch_pkg::*;
#(
  parameter int WORDS     = 80,
  parameter int WARN_W    = 8,
  parameter int WARN_UNIT = 16,
  parameter int WARN_MAX  = 138
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rowStart,
  input  logic [WARN_W-1:0] warnSetting,
  output fetch_stb_t        stb,
  output logic              busReq,
  output logic              rowDone,
  output logic              bufHalf
);

  localparam int IDX_W  = $clog2(WORDS);
  localparam int CNT_W  = $clog2(WARN_MAX + 1);
  localparam int PROD_W = WARN_W + $clog2(WARN_UNIT) + 1;

  fetch_state_t      state;
  logic [CNT_W-1:0]  warnCnt;
  logic [1:0]        phase;
  logic [IDX_W-1:0]  wordIdx;
  logic              pending;
  logic              half;
  logic              startNow;
  logic              active;
  logic [PROD_W-1:0] warnProd;
  logic [CNT_W-1:0]  warnClocks;

  always_comb begin
    warnProd = PROD_W'(warnSetting) * PROD_W'(WARN_UNIT);
    if (warnProd > PROD_W'(WARN_MAX)) warnClocks = CNT_W'(WARN_MAX);
    else                              warnClocks = CNT_W'(warnProd);
  end

  assign active   = (state == ST_WARN) || (state == ST_BUS) || (state == ST_TAIL);
  assign startNow = ((state == ST_IDLE) || (state == ST_FIN)) && (rowStart || pending);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      warnCnt <= '0;
      phase   <= '0;
      wordIdx <= '0;
    end else if (startNow) begin
      state   <= (warnClocks == '0) ? ST_BUS : ST_WARN;
      warnCnt <= warnClocks;
      phase   <= '0;
      wordIdx <= '0;
    end else begin
      case (state)
        ST_WARN: begin
          if (warnCnt == CNT_W'(1)) state <= ST_BUS;
          warnCnt <= warnCnt - CNT_W'(1);
        end
        ST_BUS: begin
          if (phase == 2'd2) begin
            phase <= '0;
            if (wordIdx == IDX_W'(WORDS - 1)) state <= ST_TAIL;
            else wordIdx <= wordIdx + IDX_W'(1);
          end else begin
            phase <= phase + 2'd1;
          end
        end
        ST_TAIL: state <= ST_FIN;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      half    <= 1'b0;
    end else begin
      if (startNow)               pending <= 1'b0;
      else if (rowStart && active) pending <= 1'b1;
      if (state == ST_FIN) half <= ~half;
    end
  end

  always_comb begin
    stb.loadBase = startNow;
    stb.drvAddr  = (state == ST_BUS) && (phase != 2'd2);
    stb.addrStb  = (state == ST_BUS) && (phase != 2'd0);
    stb.dataStb  = (state == ST_BUS) && (phase == 2'd2);
  end

  assign busReq  = active;
  assign rowDone = (state == ST_FIN);
  assign bufHalf = half;

  // R5: loaded warning count never exceeds the clamp
  a_r5_warn_clamp: assert property (@(posedge clk) disable iff (!rstN)
    warnCnt <= CNT_W'(WARN_MAX));

  // R7: done cycle has the request dropped, after a cycle with it raised
  a_r7_done_drops_req: assert property (@(posedge clk) disable iff (!rstN)
    rowDone |-> (!busReq && $past(busReq)));

  // R9: a held request restarts the bus request right after done
  a_r9_pending_restart: assert property (@(posedge clk) disable iff (!rstN)
    (rowDone && pending) |=> busReq);

endmodule

// File: rtl/dispfetch_dpath.sv
module dispfetch_dpath
  import dispfetch_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int WORDS = 80
) (
  input  logic             clk,
  input  logic             rstN,
  input  fetch_stb_t       stb,
  input  logic [BUS_W:0]   baseAddr,
  input  logic [BUS_W-1:0] busIn,
  output logic [BUS_W-1:0] busOut,
  output logic             busOe,
  output logic             addrStbN,
  output logic             upperStbN,
  output logic             lowerStbN,
  output logic             readNotWrite,
  output logic             bufWrEn,
  output logic [$clog2(WORDS)-1:0] bufWrAddr,
  output logic [BUS_W-1:0] bufWrData
);

  localparam int IDX_W = $clog2(WORDS);

  logic [BUS_W-1:0] wordAddr;
  logic [IDX_W-1:0] wrIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordAddr  <= '0;
      wrIdx     <= '0;
      bufWrEn   <= 1'b0;
      bufWrAddr <= '0;
      bufWrData <= '0;
    end else begin
      bufWrEn <= stb.dataStb;
      if (stb.loadBase) begin
        wordAddr <= baseAddr[BUS_W:1];
        wrIdx    <= '0;
      end else if (stb.dataStb) begin
        wordAddr  <= wordAddr + BUS_W'(1);
        wrIdx     <= wrIdx + IDX_W'(1);
        bufWrAddr <= wrIdx;
        bufWrData <= busIn;
      end
    end
  end

  assign busOut       = stb.drvAddr ? wordAddr : '0;
  assign busOe        = stb.drvAddr;
  assign addrStbN     = ~stb.addrStb;
  assign upperStbN    = ~stb.dataStb;
  assign lowerStbN    = ~stb.dataStb;
  assign readNotWrite = 1'b1;

  // R3: bus is released whenever data strobes are active
  a_r3_float_in_data: assert property (@(posedge clk) disable iff (!rstN)
    !upperStbN |-> !busOe);

  // R3: address strobe already low in the cycle before the data strobes fall
  a_r3_addr_first: assert property (@(posedge clk) disable iff (!rstN)
    $fell(upperStbN) |-> (!addrStbN && $past(!addrStbN)));

  // R6: a buffer write follows a data strobe cycle
  a_r6_write_after_data: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> $past(!upperStbN));

endmodule

// File: rtl/dispfetch_top.sv
module dispfetch_top
  import dispfetch_pkg::*;
#(
  parameter int BUS_W     = 16,
  parameter int WORDS     = 80,
  parameter int WARN_W    = 8,
  parameter int WARN_UNIT = 16,
  parameter int WARN_MAX  = 138
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rowStart,
  input  logic [BUS_W:0]           baseAddr,
  input  logic [WARN_W-1:0]        warnSetting,
  output logic                     busReq,
  output logic [BUS_W-1:0]         busOut,
  output logic                     busOe,
  input  logic [BUS_W-1:0]         busIn,
  output logic                     addrStbN,
  output logic                     upperStbN,
  output logic                     lowerStbN,
  output logic                     readNotWrite,
  output logic                     bufWrEn,
  output logic [$clog2(WORDS)-1:0] bufWrAddr,
  output logic [BUS_W-1:0]         bufWrData,
  output logic                     bufHalf,
  output logic                     rowDone
);

  fetch_stb_t stb;

  dispfetch_ctrl #(
    .WORDS(WORDS), .WARN_W(WARN_W), .WARN_UNIT(WARN_UNIT), .WARN_MAX(WARN_MAX)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .rowStart(rowStart), .warnSetting(warnSetting),
    .stb(stb), .busReq(busReq), .rowDone(rowDone), .bufHalf(bufHalf)
  );

  dispfetch_dpath #(
    .BUS_W(BUS_W), .WORDS(WORDS)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .stb(stb), .baseAddr(baseAddr), .busIn(busIn),
    .busOut(busOut), .busOe(busOe), .addrStbN(addrStbN),
    .upperStbN(upperStbN), .lowerStbN(lowerStbN), .readNotWrite(readNotWrite),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData)
  );

endmodule

// File: tb/dispfetch_top_tb_top.sv
`timescale 1ns/1ps
module dispfetch_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rowStart = 1'b0;
  logic [16:0] baseAddr = '0;
  logic [7:0]  warnSetting = '0;
  logic        busReq, busOe, addrStbN, upperStbN, lowerStbN, readNotWrite;
  logic        bufWrEn, bufHalf, rowDone;
  logic [15:0] busOut, busIn, bufWrData, latchAddr;
  logic [6:0]  bufWrAddr;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit expHalf = 1'b0;

  always #2.5 clk = ~clk;

  dispfetch_top dut_i (
    .clk(clk), .rstN(rstN), .rowStart(rowStart), .baseAddr(baseAddr),
    .warnSetting(warnSetting), .busReq(busReq), .busOut(busOut), .busOe(busOe),
    .busIn(busIn), .addrStbN(addrStbN), .upperStbN(upperStbN),
    .lowerStbN(lowerStbN), .readNotWrite(readNotWrite), .bufWrEn(bufWrEn),
    .bufWrAddr(bufWrAddr), .bufWrData(bufWrData), .bufHalf(bufHalf),
    .rowDone(rowDone)
  );

  // external address latch and memory model
  function automatic logic [15:0] memData(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  always @(negedge addrStbN) latchAddr <= busOut;
  assign busIn = (!upperStbN && !lowerStbN) ? memData(latchAddr) : 16'hDEAD;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic runRow(input logic [16:0] base, input int setting,
                        input bit chained, input int injAt);
    int w;
    int eReq = 0, eBus = 0, eAdr = 0, eWr = 0, eDone = 0, eRnw = 0;
    logic [31:0] aBus = 0, xBus = 0, aAdr = 0, xAdr = 0, aWr = 0, xWr = 0;
    w = setting * 16;
    if (w > 138) w = 138;
    baseAddr = base;
    warnSetting = setting[7:0];
    if (!chained) begin
      @(negedge clk);
      rowStart = 1'b1;
      @(negedge clk);
      rowStart = 1'b0;
    end else begin
      @(negedge clk);
    end
    for (int k = 0; k <= w + 241; k++) begin
      int j;
      bit inBus, eOe, eAs, eDs, eW;
      int ph, wi;
      logic [15:0] wa;
      if (k > 0) @(negedge clk);
      if (injAt >= 0 && k == injAt) rowStart = 1'b1;
      if (injAt >= 0 && k == injAt + 1) rowStart = 1'b0;
      j = k - w;
      inBus = (j >= 0) && (j < 240);
      ph = inBus ? j % 3 : 0;
      wi = inBus ? j / 3 : 0;
      eOe = inBus && ph != 2;
      eAs = !(inBus && ph != 0);
      eDs = !(inBus && ph == 2);
      if (busReq !== (k <= w + 240)) eReq++;
      if (rowDone !== (k == w + 241)) eDone++;
      if (readNotWrite !== 1'b1) eRnw++;
      if (busOe !== eOe || addrStbN !== eAs || upperStbN !== eDs || lowerStbN !== eDs) begin
        if (eBus == 0) begin
          aBus = {busOe, addrStbN, upperStbN, lowerStbN};
          xBus = {eOe, eAs, eDs, eDs};
        end
        eBus++;
      end
      wa = 16'(base[16:1] + 16'(wi));
      if (eOe && busOut !== wa) begin
        if (eAdr == 0) begin aAdr = busOut; xAdr = wa; end
        eAdr++;
      end
      eW = (j >= 3) && (j <= 240) && (j % 3 == 0);
      if (bufWrEn !== eW) begin
        if (eWr == 0) begin aWr = bufWrEn; xWr = eW; end
        eWr++;
      end else if (eW) begin
        logic [15:0] wa2;
        wa2 = 16'(base[16:1] + 16'(j / 3 - 1));
        if (bufWrAddr !== 7'(j / 3 - 1) || bufWrData !== memData(wa2) || bufHalf !== expHalf) begin
          if (eWr == 0) begin
            aWr = {bufHalf, 8'(bufWrAddr), bufWrData};
            xWr = {expHalf, 8'(j / 3 - 1), memData(wa2)};
          end
          eWr++;
        end
      end
    end
    check(eReq == 0, "R5", "busReq window", eReq, 0);
    check(eBus == 0, "R3", "strobe phases {oe,as,uds,lds}", aBus, xBus);
    check(eAdr == 0, "R4", "word address on bus", aAdr, xAdr);
    check(eWr == 0, "R6/R8", "buffer write {half,idx,data}", aWr, xWr);
    check(eDone == 0, "R7", "rowDone timing", eDone, 0);
    check(eRnw == 0, "R2", "read line held", eRnw, 0);
    expHalf = ~expHalf;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset values
    check({busReq, busOe, bufWrEn, rowDone, bufHalf} === 5'b0, "R1", "reset idle outputs",
          {busReq, busOe, bufWrEn, rowDone, bufHalf}, 0);
    check({addrStbN, upperStbN, lowerStbN} === 3'b111, "R1", "reset strobes",
          {addrStbN, upperStbN, lowerStbN}, 3'b111);
    rowStart = 1'b1;
    @(negedge clk);
    rowStart = 1'b0;
    check(busReq === 1'b0, "R1", "request ignored in reset", busReq, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busReq === 1'b0 && busOe === 1'b0, "R1", "idle after reset", busReq, 0);
    // R5 sweep of warning settings, including clamp
    for (int s = 0; s <= 10; s++)
      runRow(17'(s * 17'h0321 + 2), s, 1'b0, -1);
    runRow(17'h1_2345, 255, 1'b0, -1);      // R4 odd base, R5 clamp
    runRow(17'h1_FFF0, 1, 1'b0, -1);        // R4 wrap
    // R9: request during burst, then chained row
    runRow(17'h0_4000, 2, 1'b0, 60);
    runRow(17'h0_8000, 0, 1'b1, -1);
    runRow(17'h0_0100, 3, 1'b0, -1);
    repeat (3) @(negedge clk);
    check(busReq === 1'b0 && rowDone === 1'b0, "R9", "no extra row after pending served",
          {busReq, rowDone}, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule